// File: doc/BRIEF.md
# Timer clock select prescaler

This block turns the system clock into a one-cycle count-enable pulse for an 8-bit timer. A 3-bit source code picks where the pulse comes from. The code can stop counting, pass every clock through, or divide the clock by one of four fixed ratios. It can also count edges of an external pin, with a separate code for falling edges and for rising edges. The timer that consumes the pulse advances by one on each cycle in which the pulse is high.

Inside the block, a free-running prescale counter starts from reset and supplies all four divided rates. The counters of several timers can therefore share one phase. The external pin passes through a two-stage synchronizer and then an edge detector. The pin is never gated by its direction, so firmware that drives the pin as an output can still step the timer. A registered multiplexer selects the source, so the output changes only on clock edges.

The reset is asynchronous and active low. The block expects its deassertion to be aligned to the clock upstream.

Top module: `tmr_clksel_prescaler`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is low. Clock edges are counted from the first rising clock edge after `rst_ni` goes high. That edge is edge 1.
- R2: With source code 000 in effect, `tick_o` stays low whatever the pin does.
- R3: With code 001 sampled at a clock edge, `tick_o` is high for the cycle after that edge.
- R4: The codes 010, 011, 100 and 101 divide the clock by 8, 64, 256 and 1024. With one of these codes sampled at edge n, `tick_o` is high after edge n exactly when n is a nonzero multiple of the ratio. Each pulse is one cycle wide.
- R5: Code 110 counts falling edges of `ext_i`. Suppose a new low level of `ext_i` is first sampled at edge k, and the code is 110 at edge k+2. Then `tick_o` is high for the one cycle after edge k+2.
- R6: Code 111 follows the same timing as R5, but on rising edges of `ext_i`.
- R7: Each pin transition that is held for at least one clock produces at most one tick. A level that does not change produces no tick.
- R8: A new source code takes effect at the next clock edge. No tick is produced from a source that is not selected at that edge, including pin edges that occurred while another code was selected.
- R9: The prescale counter runs from reset and is never restarted by changes of the source code. The divided ticks stay aligned to edge multiples counted from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted in step with the clock |
| sel_i | input | 3 | Source code: stop, direct, divide by 8/64/256/1024, pin falling, pin rising |
| ext_i | input | 1 | Raw external count pin, asynchronous to the clock |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
The bench builds the block with its default parameters: a 10-bit prescale counter, taps at 3, 6, 8 and 10 bits, and a two-stage synchronizer. At these values a full wrap of the largest divider takes 1024 cycles, so every code can be swept over more than two full periods.

The pin modes are driven with hold times from one to six cycles. The codes are then switched on every cycle in a pseudo-random order while the pin toggles. This places source changes on divided-tick boundaries and next to pin edges, which is where a stale tick from the old source would show.

A second reset in mid-run confirms that the divided ticks realign to the new reset.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_TAPS = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF      = 3'd0,
    SRC_DIRECT   = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } tcs_src_e;

  // first code that maps onto a prescale tap; taps follow in order
  localparam logic [SEL_W-1:0] FIRST_TAP_CODE = SRC_DIV8;

endpackage

// File: rtl/tcs_prescale_ctr.sv
module tcs_prescale_ctr #(
  parameter int unsigned CNT_W              = 10,
  parameter int unsigned NUM_TAPS           = 4,
  parameter int unsigned TAP_LOG2[NUM_TAPS] = '{3, 6, 8, 10}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // free-running: never cleared by the source code
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // a tap fires in the cycle before its low bits roll over to zero
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_o[g] = &cnt_q[TAP_LOG2[g]-1:0];
  end

endmodule

// File: rtl/tcs_ext_edge.sv
module tcs_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   last_d;

  always_comb begin
    sync_d = {sync_q[MSB-1:0], ext_i};
    last_d = sync_q[MSB];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o =  sync_q[MSB] & ~last_q;
  assign fall_o = ~sync_q[MSB] &  last_q;

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
#(
  parameter int unsigned NUM_TAPS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);

  logic tick_d;
  logic tick_q;

  always_comb begin
    tick_d = 1'b0;
    case (sel_i)
      SRC_OFF:      tick_d = 1'b0;
      SRC_DIRECT:   tick_d = 1'b1;
      SRC_EXT_FALL: tick_d = fall_i;
      SRC_EXT_RISE: tick_d = rise_i;
      default: begin
        for (int i = 0; i < NUM_TAPS; i++) begin
          if (sel_i == FIRST_TAP_CODE + SEL_W'(i)) begin
            tick_d = tap_i[i];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/tmr_clksel_prescaler.sv
module tmr_clksel_prescaler
  import tcs_pkg::*;
#(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_i,
  output logic             tick_o
);

  localparam int unsigned TAP_LOG2[NUM_TAPS] = '{3, 6, 8, CNT_W};

  logic [NUM_TAPS-1:0] tap;
  logic                ext_rise;
  logic                ext_fall;

  tcs_prescale_ctr #(
    .CNT_W    (CNT_W),
    .NUM_TAPS (NUM_TAPS),
    .TAP_LOG2 (TAP_LOG2)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap)
  );

  tcs_ext_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  tcs_src_mux #(
    .NUM_TAPS (NUM_TAPS)
  ) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .tap_i  (tap),
    .rise_i (ext_rise),
    .fall_i (ext_fall),
    .tick_o (tick_o)
  );

endmodule

// File: rtl/tcs_sva_chk.sv
module tcs_sva_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       ext_i,
  input logic       tick_o
);

  localparam int unsigned CHK_LOG2[4] = '{3, 6, 8, CNT_W};

  logic [CNT_W-1:0] edge_cnt;
  logic             p1, p2, p3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_cnt <= '0;
      p1 <= 1'b0;
      p2 <= 1'b0;
      p3 <= 1'b0;
    end else begin
      edge_cnt <= edge_cnt + CNT_W'(1);
      p1 <= ext_i;
      p2 <= p1;
      p3 <= p2;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!tick_o);
    end
  end

  a_r2_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |=> !tick_o);

  a_r3_direct_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd1) |=> tick_o);

  for (genvar g = 0; g < 4; g++) begin : g_div
    a_r4_div_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'(2 + g) && (&edge_cnt[CHK_LOG2[g]-1:0])) |=> tick_o);
    a_r4_div_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i == 3'(2 + g) && !(&edge_cnt[CHK_LOG2[g]-1:0])) |=> !tick_o);
  end

  a_r5_fall_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd6 && p3 && !p2) |=> tick_o);

  a_r6_rise_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd7 && p2 && !p3) |=> tick_o);

  a_r8_no_stale_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i >= 3'd6 && (p2 == p3)) |=> !tick_o);

endmodule

bind tmr_clksel_prescaler tcs_sva_chk #(.CNT_W(CNT_W)) u_sva_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .ext_i  (ext_i),
  .tick_o (tick_o)
);

// File: tb/tmr_clksel_prescaler_tb_top.sv
module tmr_clksel_prescaler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       ext = 1'b0;
  wire        tick;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    e;
  logic  exp_t;
  logic  h1, h2, h3;
  logic [2:0] sel_cap;
  string phase = "";
  bit    done = 0;

  always #10 clk = ~clk;

  tmr_clksel_prescaler dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .ext_i  (ext),
    .tick_o (tick)
  );

  // expected tick after edge n with code s; a = newer, b = older pin sample
  function automatic logic model(logic [2:0] s, int n, logic a, logic b);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return (n % 8) == 0;
      3'd3: return (n % 64) == 0;
      3'd4: return (n % 256) == 0;
      3'd5: return (n % 1024) == 0;
      3'd6: return b & ~a;
      default: return a & ~b;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e <= 0; exp_t <= 1'b0; h1 <= 1'b0; h2 <= 1'b0; h3 <= 1'b0; sel_cap <= 3'd0;
    end else begin
      e       <= e + 1;
      exp_t   <= model(sel, e + 1, h2, h3);
      sel_cap <= sel;
      h1 <= ext; h2 <= h1; h3 <= h2;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (!rst_n) begin
        if (tick !== 1'b0) begin
          n_bad++;
          $display("FAIL R1 in reset: actual=%b expected=0", tick);
        end
      end else if (tick !== exp_t) begin
        n_bad++;
        $display("FAIL %s%s edge %0d code %0d: actual=%b expected=%b",
                 req_of(sel_cap), phase, e, sel_cap, tick, exp_t);
      end
    end
  end

  task automatic run(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic toggle_ext(int rounds);
    for (int r = 0; r < rounds; r++) begin
      for (int hold = 1; hold <= 6; hold++) begin
        ext = ~ext;
        run(hold);
      end
    end
  endtask

  initial begin
    logic [7:0] lfsr;
    run(4);                          // R1: checked in reset
    rst_n = 1'b1;
    for (int s = 0; s <= 5; s++) begin  // R2 R3 R4
      sel = 3'(s);
      run(s >= 4 ? 2100 : 300);
    end
    sel = 3'd6; toggle_ext(20);      // R5 R7
    sel = 3'd7; toggle_ext(20);      // R6 R7
    run(50);                         // R7 steady level: no ticks
    phase = "/R8";                   // R8: code changes every cycle
    lfsr = 8'hA5;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sel  = lfsr[2:0];
      if (lfsr[6]) ext = ~ext;
      run(1);
    end
    phase = "/R9";                   // R9: phase kept after switching
    sel = 3'd2; run(200);
    sel = 3'd3; run(400);
    sel = 3'd1;                      // R1: second reset, then realign
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    sel = 3'd2; run(100);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule